// File: doc/BRIEF.md
# Windowed Register File Controller

The block is an integer register file laid out as a ring of overlapping windows. Every window offers 32 logical registers. A pointer selects the active window, and the block turns each logical register number into a physical slot in one bank. Windows next to each other in the ring share eight registers. A caller can therefore pass arguments in its outgoing registers, and after a pointer decrement the callee finds them in its incoming registers.

Software controls the ring with save, restore and trap-entry strobes. A mask register marks windows that may not be entered. A save or restore that would land on a marked window is refused, and the block flags an overflow or an underflow. Software then spills or fills windows to memory and retries; this block takes no part in that. Trap entry moves the pointer without checking the mask, so a handler always gets a fresh set of locals. The window count is a parameter from 2 to 32. The physical bank holds 8 shared registers plus 16 per window, which is 40 registers at the minimum of two windows.

Top module: `regwin_file`

## Requirements
- R1: Logical register numbers decode by bits [4:3]: 0 to 7 are shared by all windows, 8 to 15 are the window's outgoing group, 16 to 23 its locals and 24 to 31 its incoming group. Locals and incoming registers are private to each window.
- R2: Outgoing register 8+k of window w is the same physical register as incoming register 24+k of window (w-1) mod NWIN.
- R3: Logical register 0 always reads as zero on both read ports, and writes to it are discarded.
- R4: A save decrements the pointer and a restore increments it, modulo NWIN. The new value appears on cwp_o after the clock edge that accepts the move. With no strobe, the pointer holds.
- R5: If the mask bit of window (cwp-1) mod NWIN is set, a save leaves the pointer unchanged and ovf_o is high for exactly the next cycle. ovf_o and unf_o are never high together.
- R6: If the mask bit of window (cwp+1) mod NWIN is set, a restore leaves the pointer unchanged and unf_o is high for exactly the next cycle.
- R7: Trap entry decrements the pointer modulo NWIN whatever the mask holds and raises no flag. Trap entry takes priority over save, and save over restore, when strobes arrive in the same cycle.
- R8: While wim_we_i is high, the mask (bit w for window w) loads wim_i at the clock edge. A move in that same cycle is checked against the old mask.
- R9: Reset sets the pointer to 0, clears the mask, clears every physical register and holds both flags low.
- R10: Reads are combinational through the current pointer. A write maps through the pointer as it stands before any move in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_a_i | input | 5 | Logical register number, read port A |
| ra_b_i | input | 5 | Logical register number, read port B |
| rd_a_o | output | DW | Read data, port A |
| rd_b_o | output | DW | Read data, port B |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Logical register number, write port |
| wd_i | input | DW | Write data |
| save_i | input | 1 | Save strobe (pointer decrement) |
| restore_i | input | 1 | Restore strobe (pointer increment) |
| trap_i | input | 1 | Trap-entry strobe (unchecked decrement) |
| wim_we_i | input | 1 | Mask write enable |
| wim_i | input | NWIN | New mask value, bit w guards window w |
| cwp_o | output | 5 | Current window pointer |
| ovf_o | output | 1 | Refused save, one-cycle pulse |
| unf_o | output | 1 | Refused restore, one-cycle pulse |

## Verification
The bench uses four windows. It writes a distinct tag into every logical register of every window, stepping forward with restores. It then reads all 32 registers of each window on both ports. A wrong window base, a broken share between outgoing and incoming groups, or a missed wrap shows up as a tag that came from the wrong window. Further patterns test refused moves against a mask, a mask write in the same cycle as a move, trap entry onto a masked window, strobe collisions, writes in the same cycle as a save, and the zero register.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;
  localparam int LOG_W   = 5;
  localparam int GRP     = 8;
  localparam int PER_WIN = 2 * GRP;

  typedef enum logic [1:0] {
    REG_SHARED = 2'd0,
    REG_OUTG   = 2'd1,
    REG_LOCAL  = 2'd2,
    REG_INCG   = 2'd3
  } reg_grp_e;

  function automatic reg_grp_e grp_of(input logic [LOG_W-1:0] la);
    return reg_grp_e'(la[4:3]);
  endfunction
endpackage

// File: rtl/wrf_addr_map.sv
`timescale 1ns/1ps
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int PTR_W = 3,
  parameter int PA_W  = 8
) (
  input  logic [PTR_W-1:0] cwp_i,
  input  logic [LOG_W-1:0] la_i,
  output logic [PA_W-1:0]  pa_o
);
  // slot layout per window: incoming group first, then locals
  logic [PTR_W-1:0] prev_w;
  int unsigned      base_cur, base_prev, off;

  always_comb begin
    prev_w    = (int'(cwp_i) == 0) ? PTR_W'(NWIN - 1) : cwp_i - 1'b1;
    base_cur  = GRP + PER_WIN * int'(cwp_i);
    base_prev = GRP + PER_WIN * int'(prev_w);
    off       = int'(la_i[2:0]);
    unique case (grp_of(la_i))
      REG_SHARED: pa_o = PA_W'(off);
      REG_OUTG:   pa_o = PA_W'(base_prev + off);
      REG_LOCAL:  pa_o = PA_W'(base_cur + GRP + off);
      REG_INCG:   pa_o = PA_W'(base_cur + off);
      default:    pa_o = '0;
    endcase
  end
endmodule

// File: rtl/wrf_bank.sv
`timescale 1ns/1ps
module wrf_bank #(
  parameter int DEPTH = 136,
  parameter int DW    = 32,
  parameter int PA_W  = 8,
  parameter int NRD   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NRD*PA_W-1:0] ra_i,
  output logic [NRD*DW-1:0]   rd_o,
  input  logic                we_i,
  input  logic [PA_W-1:0]     wa_i,
  input  logic [DW-1:0]       wd_i
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && int'(wa_i) < DEPTH) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [PA_W-1:0] a;
    assign a = ra_i[p*PA_W +: PA_W];
    assign rd_o[p*DW +: DW] = (int'(a) < DEPTH) ? mem_q[a] : '0;
  end

  AST_WADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> int'(wa_i) < DEPTH); // R1
endmodule

// File: rtl/wrf_window_ctl.sv
`timescale 1ns/1ps
module wrf_window_ctl #(
  parameter int NWIN  = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             trap_i,
  input  logic             wim_we_i,
  input  logic [NWIN-1:0]  wim_i,
  output logic [PTR_W-1:0] cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [PTR_W-1:0] cwp_q, cwp_d, dec_w, inc_w;
  logic [NWIN-1:0]  wim_q;
  logic             ovf_q, unf_q;
  logic             do_save, do_rest, save_blk, rest_blk;

  always_comb begin
    dec_w    = (int'(cwp_q) == 0)        ? PTR_W'(NWIN - 1) : cwp_q - 1'b1;
    inc_w    = (int'(cwp_q) == NWIN - 1) ? '0               : cwp_q + 1'b1;
    do_save  = save_i & ~trap_i;
    do_rest  = restore_i & ~trap_i & ~save_i;
    save_blk = do_save & wim_q[dec_w];
    rest_blk = do_rest & wim_q[inc_w];
    cwp_d    = cwp_q;
    if (trap_i || (do_save && !save_blk)) cwp_d = dec_w;
    else if (do_rest && !rest_blk)        cwp_d = inc_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      wim_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cwp_q <= cwp_d;
      ovf_q <= save_blk;
      unf_q <= rest_blk;
      if (wim_we_i) wim_q <= wim_i;
    end
  end

  assign cwp_o = cwp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cwp_q) < NWIN); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && !restore_i && !trap_i) |=> cwp_q == $past(cwp_q)); // R4
  AST_NO_OVF_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !trap_i && wim_q[dec_w]) |=> (ovf_o && cwp_q == $past(cwp_q))); // R5
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o)); // R5
  AST_NO_UNF_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !trap_i && wim_q[inc_w]) |=> (unf_o && cwp_q == $past(cwp_q))); // R6
  AST_TRAP_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (cwp_q == $past(dec_w) && !ovf_o && !unf_o)); // R7
endmodule

// File: rtl/regwin_file.sv
`timescale 1ns/1ps
module regwin_file
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      ra_a_i,
  input  logic [4:0]      ra_b_i,
  output logic [DW-1:0]   rd_a_o,
  output logic [DW-1:0]   rd_b_o,
  input  logic            we_i,
  input  logic [4:0]      wa_i,
  input  logic [DW-1:0]   wd_i,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            trap_i,
  input  logic            wim_we_i,
  input  logic [NWIN-1:0] wim_i,
  output logic [4:0]      cwp_o,
  output logic            ovf_o,
  output logic            unf_o
);
  localparam int PTR_W = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int DEPTH = GRP + PER_WIN * NWIN;
  localparam int PA_W  = $clog2(DEPTH);
  localparam int NPORT = 3; // two reads, one write

  logic [PTR_W-1:0]       cwp;
  logic [LOG_W-1:0]       la   [NPORT];
  logic [PA_W-1:0]        pa   [NPORT];
  logic [2*PA_W-1:0]      ra_pk;
  logic [2*DW-1:0]        rd_pk;

  assign la[0] = ra_a_i;
  assign la[1] = ra_b_i;
  assign la[2] = wa_i;

  wrf_window_ctl #(.NWIN(NWIN), .PTR_W(PTR_W)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .save_i    (save_i),
    .restore_i (restore_i),
    .trap_i    (trap_i),
    .wim_we_i  (wim_we_i),
    .wim_i     (wim_i),
    .cwp_o     (cwp),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    wrf_addr_map #(.NWIN(NWIN), .PTR_W(PTR_W), .PA_W(PA_W)) u_map (
      .cwp_i (cwp),
      .la_i  (la[p]),
      .pa_o  (pa[p])
    );
  end

  assign ra_pk = {pa[1], pa[0]};

  wrf_bank #(.DEPTH(DEPTH), .DW(DW), .PA_W(PA_W), .NRD(2)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (ra_pk),
    .rd_o   (rd_pk),
    .we_i   (we_i && (wa_i != '0)),
    .wa_i   (pa[2]),
    .wd_i   (wd_i)
  );

  assign rd_a_o = (ra_a_i == '0) ? '0 : rd_pk[0 +: DW];
  assign rd_b_o = (ra_b_i == '0) ? '0 : rd_pk[DW +: DW];
  assign cwp_o  = 5'(cwp);

  AST_ZERO_RD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_a_i == 5'd0) |-> rd_a_o == '0); // R3
  AST_ZERO_RD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_b_i == 5'd0) |-> rd_b_o == '0); // R3
endmodule

// File: tb/regwin_file_test.sv
`timescale 1ns/1ps
module regwin_file_test;
  localparam int NW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    ra_a = '0, ra_b = '0, wa = '0;
  logic [DW-1:0] rd_a, rd_b, wd = '0;
  logic          we = 1'b0, save = 1'b0, rest = 1'b0, trap = 1'b0, wim_we = 1'b0;
  logic [NW-1:0] wim = '0;
  logic [4:0]    cwp;
  logic          ovf, unf;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [8 + 16*NW];
  int cur = 0;

  always #4 clk = ~clk;

  regwin_file #(.NWIN(NW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ra_a_i(ra_a), .ra_b_i(ra_b),
    .rd_a_o(rd_a), .rd_b_o(rd_b), .we_i(we), .wa_i(wa), .wd_i(wd),
    .save_i(save), .restore_i(rest), .trap_i(trap), .wim_we_i(wim_we),
    .wim_i(wim), .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf)
  );

  // bench-side mapping: window w slots at 8+16w (incoming 0..7, locals 8..15)
  function automatic int phys(int w, int r);
    if (r < 8)  return r;
    if (r < 16) return 8 + 16*((w + NW - 1) % NW) + (r - 8);
    if (r < 24) return 8 + 16*w + 8 + (r - 16);
    return 8 + 16*w + (r - 24);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; save = 1'b0; rest = 1'b0; trap = 1'b0; wim_we = 1'b0;
  endtask

  task automatic write_reg(int r, logic [31:0] v);
    we = 1'b1; wa = 5'(r); wd = v;
    step();
    if (r != 0) model[phys(cur, r)] = v;
  endtask

  task automatic read_all(string req);
    for (int r = 0; r < 32; r++) begin
      ra_a = 5'(r); ra_b = 5'(31 - r);
      #1;
      check(req, rd_a, (r == 0) ? 32'h0 : model[phys(cur, r)]);
      check(req, rd_b, (r == 31) ? 32'h0 : model[phys(cur, 31 - r)]);
    end
  endtask

  task automatic set_mask(logic [NW-1:0] m);
    wim = m; wim_we = 1'b1;
    step();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8 + 16*NW; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 cwp", 32'(cwp), 0);
    check("R9 ovf", 32'(ovf), 0);
    check("R9 unf", 32'(unf), 0);
    read_all("R9 regs clear");

    // R1 R2 R4: fill every window, stepping forward with restores
    for (int w = 0; w < NW; w++) begin
      for (int r = 0; r < 32; r++) write_reg(r, 32'hC0DE_0000 | 32'(w << 8) | 32'(r));
      rest = 1'b1;
      step();
      cur = (cur + 1) % NW;
      check("R4 restore increment", 32'(cwp), 32'(cur));
    end
    // R1 R2 R3: every window read back on both ports
    for (int w = 0; w < NW; w++) begin
      read_all("R1/R2 window map");
      save = 1'b1;
      step();
      cur = (cur + NW - 1) % NW;
      check("R4 save decrement wrap", 32'(cwp), 32'(cur));
    end
    // R2 explicit: outgoing of cur equals incoming of cur-1
    ra_a = 5'd9; #1;
    check("R2 shared out", rd_a, 32'hC0DE_0000 | 32'(((cur + NW - 1) % NW) << 8) | 32'd25);

    // R10: write in the same cycle as a save lands in the old window
    we = 1'b1; wa = 5'd20; wd = 32'h1234_5678; save = 1'b1;
    step();
    model[phys(cur, 20)] = 32'h1234_5678;
    cur = (cur + NW - 1) % NW;
    check("R10 save moved", 32'(cwp), 32'(cur));
    rest = 1'b1; step(); cur = (cur + 1) % NW;
    ra_a = 5'd20; #1;
    check("R10 write before move", rd_a, 32'h1234_5678);

    // R3 zero register write discarded
    write_reg(0, 32'hFFFF_FFFF);
    ra_a = 5'd0; ra_b = 5'd0; #1;
    check("R3 zero A", rd_a, 0);
    check("R3 zero B", rd_b, 0);

    // R5 blocked save
    set_mask(NW'(1) << ((cur + NW - 1) % NW));
    save = 1'b1; step();
    check("R5 ptr held", 32'(cwp), 32'(cur));
    check("R5 ovf pulse", 32'(ovf), 1);
    check("R5 no unf", 32'(unf), 0);
    step();
    check("R5 ovf one cycle", 32'(ovf), 0);

    // R6 blocked restore
    set_mask(NW'(1) << ((cur + 1) % NW));
    rest = 1'b1; step();
    check("R6 ptr held", 32'(cwp), 32'(cur));
    check("R6 unf pulse", 32'(unf), 1);
    check("R6 no ovf", 32'(ovf), 0);
    step();
    check("R6 unf one cycle", 32'(unf), 0);

    // R8: mask loaded in same cycle as a restore does not block it
    wim = NW'(1) << ((cur + 1) % NW) | NW'(1) << ((cur + 2) % NW);
    wim_we = 1'b1; rest = 1'b0;
    step();
    wim = '0; wim_we = 1'b1; rest = 1'b1; // old mask blocks, new mask cleared
    step();
    check("R8 old mask used", 32'(unf), 1);
    check("R8 old mask ptr", 32'(cwp), 32'(cur));
    rest = 1'b1; step(); cur = (cur + 1) % NW;
    check("R8 new mask used", 32'(cwp), 32'(cur));
    check("R8 no flag", 32'(unf), 0);

    // R7: trap onto a masked window, and strobe priority
    set_mask(NW'(1) << ((cur + NW - 1) % NW));
    trap = 1'b1; save = 1'b1; rest = 1'b1; step();
    cur = (cur + NW - 1) % NW;
    check("R7 trap ignores mask", 32'(cwp), 32'(cur));
    check("R7 trap no ovf", 32'(ovf), 0);
    check("R7 trap no unf", 32'(unf), 0);
    set_mask('0);
    save = 1'b1; rest = 1'b1; step();
    cur = (cur + NW - 1) % NW;
    check("R7 save over restore", 32'(cwp), 32'(cur));
    read_all("R1 after moves");

    // R4 hold with no strobe
    step();
    check("R4 idle hold", 32'(cwp), 32'(cur));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule